// File: doc/BRIEF.md
# Control-Transfer Condition and Target Unit

This block decides, in a single combinational step, whether a control transfer takes place and where it goes. One 4-bit condition field serves both PC-relative branches and register-indirect jumps. That field covers an unconditional case, two zero tests, four signed comparisons and four unsigned comparisons. The comparisons are evaluated against the zero, carry, negative and overflow flags produced by an earlier compare.

A 2-bit mode selects the kind of transfer:

- **Relative branch** (`2'b00`): the target is the PC plus a sign-extended 8-bit offset.
- **Register jump** (`2'b01`): the target is the supplied register value.
- **Call** (`2'b10`): transfers unconditionally to the register value and presents the current PC as a return value, together with a write enable for it.
- **Idle** (`2'b11`): requests no transfer.

Condition codes 11 to 15 are undefined. They are never taken and they raise a flag that the decoder can trap on. All results depend only on the present inputs, so a surrounding pipeline stage can use them in the same cycle.

Top module: `xfer_unit`

## Requirements
- R1: In modes `2'b00` and `2'b01`, condition code 0 makes `taken` 1 whatever the flags are.
- R2: Code 1 is taken exactly when `flag_z`=1, and code 2 is taken exactly when `flag_z`=0.
- R3: The signed codes behave as follows.
  - Code 3 is taken when Z=1 or N≠V.
  - Code 4 is taken when Z=0 and N≠V.
  - Code 5 is taken when Z=1 or N=V.
  - Code 6 is taken when Z=0 and N=V.
- R4: The unsigned codes behave as follows.
  - Code 7 is taken when Z=1 or C=1.
  - Code 8 is taken when Z=0 and C=1.
  - Code 9 is taken when Z=1 or C=0.
  - Code 10 is taken when Z=0 and C=0.
- R5: In modes `2'b00` and `2'b01`, codes 11..15 give `taken`=0 and `bad_cond`=1. Codes 0..10 give `bad_cond`=0.
- R6: In mode `2'b00`, `target` is `pc` plus `offset` read as a two's-complement value in −128..127.
- R7: In mode `2'b01`, `target` equals `reg_val`.
- R8: In mode `2'b10`, the outputs are as follows, independent of `cond` and the flags.
  - `taken`=1 and `target`=`reg_val`.
  - `link_we`=1 and `link_val`=`pc`.
  - `bad_cond`=0.
- R9: In every mode other than `2'b10`, `link_we`=0. In mode `2'b11`, `taken`=0, `bad_cond`=0 and `target`=`pc`.
- R10: The branch target addition wraps modulo 2^16, with no carry out and no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond | input | 4 | Condition code 0..15 |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| mode | input | 2 | 00 branch, 01 jump, 10 call, 11 idle |
| pc | input | 16 | Current program counter |
| offset | input | 8 | Signed branch displacement |
| reg_val | input | 16 | Register operand for jump or call target |
| taken | output | 1 | Transfer happens |
| target | output | 16 | Next PC if taken |
| link_we | output | 1 | Return value is to be written |
| link_val | output | 16 | Return value (old PC) |
| bad_cond | output | 1 | Undefined condition code seen |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with zero register delay. The bench applies one input vector just after each rising edge and compares all five outputs against a behavioural model at the following falling edge. This leaves half a period for the logic to settle, and no result is read at an edge. The stimulus sweeps every condition code against all sixteen flag combinations in each mode, then runs wrap-around offsets and random vectors.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XM_BRANCH = 2'b00,
    XM_JUMP   = 2'b01,
    XM_CALL   = 2'b10,
    XM_IDLE   = 2'b11
  } xfer_mode_e;

  typedef enum logic [3:0] {
    XC_ALWAYS = 4'd0,
    XC_EQ     = 4'd1,
    XC_NE     = 4'd2,
    XC_SLE    = 4'd3,
    XC_SLT    = 4'd4,
    XC_SGE    = 4'd5,
    XC_SGT    = 4'd6,
    XC_ULE    = 4'd7,
    XC_ULT    = 4'd8,
    XC_UGE    = 4'd9,
    XC_UGT    = 4'd10
  } xfer_cond_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } flags_t;

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval
  import xfer_pkg::*;
#(
  parameter int CC_W = 4
) (
  input  logic [CC_W-1:0] cc,
  input  flags_t          fl,
  output logic            hit,
  output logic            undefined
);

  logic signed_lt;
  logic eq_zero;

  always_comb begin
    signed_lt = fl.n ^ fl.v;
    eq_zero   = fl.z;
    hit       = 1'b0;
    undefined = 1'b0;
    case (cc)
      XC_ALWAYS: hit = 1'b1;
      XC_EQ:     hit = eq_zero;
      XC_NE:     hit = !eq_zero;
      XC_SLE:    hit = eq_zero | signed_lt;
      XC_SLT:    hit = !eq_zero & signed_lt;
      XC_SGE:    hit = eq_zero | !signed_lt;
      XC_SGT:    hit = !eq_zero & !signed_lt;
      XC_ULE:    hit = eq_zero | fl.c;
      XC_ULT:    hit = !eq_zero & fl.c;
      XC_UGE:    hit = eq_zero | !fl.c;
      XC_UGT:    hit = !eq_zero & !fl.c;
      default:   undefined = 1'b1;
    endcase
  end

endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8
) (
  input  xfer_mode_e       mode,
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  reg_val,
  output logic [PC_W-1:0]  target
);

  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] rel_sum;

  generate
    if (EXT_W > 0) begin : g_sext
      assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
    end else begin : g_trunc
      assign ofs_ext = offset[PC_W-1:0];
    end
  endgenerate

  assign rel_sum = pc + ofs_ext;

  always_comb begin
    unique case (mode)
      XM_BRANCH:       target = rel_sum;
      XM_JUMP, XM_CALL: target = reg_val;
      default:         target = pc;
    endcase
  end

endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8,
  parameter int CC_W  = 4
) (
  input  logic [CC_W-1:0]  cond,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic [1:0]       mode,
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  reg_val,
  output logic             taken,
  output logic [PC_W-1:0]  target,
  output logic             link_we,
  output logic [PC_W-1:0]  link_val,
  output logic             bad_cond
);

  xfer_mode_e m;
  flags_t     fl;
  logic       cc_hit;
  logic       cc_undef;
  logic       conditional;

  assign m  = xfer_mode_e'(mode);
  assign fl = '{z: flag_z, c: flag_c, n: flag_n, v: flag_v};

  xfer_cond_eval #(.CC_W(CC_W)) u_cond (
    .cc        (cond),
    .fl        (fl),
    .hit       (cc_hit),
    .undefined (cc_undef)
  );

  xfer_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .mode    (m),
    .pc      (pc),
    .offset  (offset),
    .reg_val (reg_val),
    .target  (target)
  );

  assign conditional = (m == XM_BRANCH) || (m == XM_JUMP);

  always_comb begin
    taken    = 1'b0;
    bad_cond = 1'b0;
    link_we  = 1'b0;
    link_val = pc;
    if (conditional) begin
      taken    = cc_hit & !cc_undef;
      bad_cond = cc_undef;
    end else if (m == XM_CALL) begin
      taken   = 1'b1;
      link_we = 1'b1;
    end
  end

  always_comb begin
    a_r5_bad_never_taken: assert (!(bad_cond && taken));
    a_r1_always_taken: assert (!(conditional && cond == '0) || taken);
    a_r7_jump_target: assert (!(m == XM_JUMP) || target == reg_val);
    a_r8_call_links_pc: assert (!(m == XM_CALL) || (link_we && taken && link_val == pc && target == reg_val));
    a_r9_link_only_on_call: assert (!link_we || m == XM_CALL);
  end

endmodule

// File: tb/sim_xfer_unit.sv
module sim_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cond = '0;
  logic        fz = 1'b0, fc = 1'b0, fn = 1'b0, fv = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  offset = '0;
  logic [15:0] reg_val = '0;
  logic        taken, link_we, bad_cond;
  logic [15:0] target, link_val;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  xfer_unit u0 (
    .cond(cond), .flag_z(fz), .flag_c(fc), .flag_n(fn), .flag_v(fv),
    .mode(mode), .pc(pc), .offset(offset), .reg_val(reg_val),
    .taken(taken), .target(target), .link_we(link_we),
    .link_val(link_val), .bad_cond(bad_cond)
  );

  function automatic bit ref_hit(int cc, bit z, bit c, bit n, bit v);
    case (cc)
      0: return 1;
      1: return z;
      2: return !z;
      3: return z || (n != v);
      4: return !z && (n != v);
      5: return z || (n == v);
      6: return !z && (n == v);
      7: return z || c;
      8: return !z && c;
      9: return z || !c;
      10: return !z && !c;
      default: return 0;
    endcase
  endfunction

  function automatic string cc_tag(int md, int cc);
    if (md == 2) return "R8";
    if (md == 3) return "R9";
    if (cc == 0) return "R1";
    if (cc <= 2) return "R2";
    if (cc <= 6) return "R3";
    if (cc <= 10) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic apply(int cc, int flags, int md, int p, int ofs, int rv, string ttag);
    int e_taken, e_tgt, e_lwe, e_bad, sofs;
    @(posedge clk);
    #1;
    cond = cc[3:0]; fz = flags[3]; fc = flags[2]; fn = flags[1]; fv = flags[0];
    mode = md[1:0]; pc = p[15:0]; offset = ofs[7:0]; reg_val = rv[15:0];
    sofs = (ofs[7:0] >= 128) ? int'(ofs[7:0]) - 256 : int'(ofs[7:0]);
    case (md)
      0, 1: begin
        e_taken = ref_hit(cc, flags[3], flags[2], flags[1], flags[0]) ? 1 : 0;
        e_bad = (cc > 10) ? 1 : 0;
        e_lwe = 0;
        e_tgt = (md == 0) ? ((p[15:0] + sofs) & 16'hFFFF) : int'(rv[15:0]);
      end
      2: begin e_taken = 1; e_bad = 0; e_lwe = 1; e_tgt = int'(rv[15:0]); end
      default: begin e_taken = 0; e_bad = 0; e_lwe = 0; e_tgt = int'(p[15:0]); end
    endcase
    @(negedge clk);
    chk(cc_tag(md, cc), "taken", int'(taken), e_taken);
    chk((cc > 10 && md < 2) ? "R5" : cc_tag(md, cc), "bad_cond", int'(bad_cond), e_bad);
    chk(ttag, "target", int'(target), e_tgt);
    chk(md == 2 ? "R8" : "R9", "link_we", int'(link_we), e_lwe);
    if (md == 2) chk("R8", "link_val", int'(link_val), int'(p[15:0]));
  endtask

  function automatic string tgt_tag(int md);
    case (md)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // reset-state vector: all inputs zero -> branch, code 0, target 0
    chk("R1", "reset taken", int'(taken), 1);
    chk("R6", "reset target", int'(target), 0);
    chk("R9", "reset link_we", int'(link_we), 0);
    chk("R5", "reset bad_cond", int'(bad_cond), 0);

    // full sweep: every mode x code x flag pattern
    for (int md = 0; md < 4; md++)
      for (int cc = 0; cc < 16; cc++)
        for (int f = 0; f < 16; f++)
          apply(cc, f, md, 16'h1234 + cc, 8'hF6 + f, 16'hBEEF - f, tgt_tag(md));

    // R10 wrap-around corners
    apply(0, 0, 0, 16'hFFF0, 8'h20, 0, "R10");
    apply(0, 0, 0, 16'h0005, 8'h80, 0, "R10");
    apply(0, 0, 0, 16'hFFFF, 8'h01, 0, "R10");
    apply(0, 0, 0, 16'h0000, 8'hFF, 0, "R10");
    apply(0, 0, 0, 16'h7FFF, 8'h7F, 0, "R6");

    // random vectors
    for (int i = 0; i < 3000; i++) begin
      int md = int'($urandom_range(3, 0));
      apply(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)), md,
            int'($urandom_range(16'hFFFF, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(16'hFFFF, 0)), tgt_tag(md));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule